// File: doc/BRIEF.md
# Multi-Queue FIFO Read-Port Switcher

This block is the read side of a small first-word-fall-through FIFO that keeps four logical queues in one shared storage array. A single write port (used by the surrounding logic or a testbench) pushes words into any queue. The read side presents the head word of the currently selected queue on a registered output with a valid flag. A read enable consumes the word on view, and the next word of the same queue appears on the following edge.

A 6-bit read address does two jobs. When the queue-select strobe is high and the top three bits equal this device's identity, the two low bits name the new read queue. The switch takes a fixed two edges and ignores the read enable. On the first edge after the capture the output still comes from the old queue. On the second edge the head of the new queue falls through. A separate strobe uses the same top three bits to decide whether this device owns the shared flag bus. Every queue keeps its own pointers and occupancy, so leaving a queue and coming back neither drops nor repeats a word.

Top module: `mq_rd_switch`

## Requirements
- R1: After a clocked reset with rst_n low, qout_valid is 0, qout is 0, all q_empty bits are 1, all q_full bits are 0 and flag_sel is 0. The read queue is queue 0.
- R2: A queue selection is captured on a rising edge only when rad_en is 1 and rdadd[5:3] equals DEV_ID. rdadd[1:0] is then the queue number and rdadd[2] has no effect. With rad_en low or a different identity, the read queue is unchanged.
- R3: On the first edge after a capturing edge, qout is still loaded from the previously selected queue, whatever ren is.
- R4: On the second edge after a capturing edge, qout shows the head word of the newly selected queue, whatever ren is.
- R5: When ren is 1 while qout_valid is 1, the word on view is removed from its queue and the next word of that queue is shown on the same edge. When ren is 0 and no switch completes, qout and qout_valid hold.
- R6: If the read queue holds no word to show, qout_valid is 0 and qout keeps its last value. A word written at edge E into that queue appears at edge E+1.
- R7: Each queue has its own read and write positions. Words come out of each queue in write order, across any number of switches, with none lost or repeated.
- R8: On an edge where estr is 1, flag_sel becomes 1 if rdadd[5:3] equals DEV_ID and 0 otherwise, and rdadd[2:0] has no effect. On edges where estr is 0, flag_sel holds.
- R9: A write to a queue that holds DEPTH words is dropped, and that queue's q_full bit is 1.
- R10: q_empty[i] is 1 exactly when queue i holds no word, and q_full[i] is 1 exactly when it holds DEPTH words. A write always leaves its queue non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Push wr_data into queue wr_queue |
| wr_queue | input | 2 | Target queue of a push |
| wr_data | input | DATA_W | Word to push |
| ren | input | 1 | Consume the word on view |
| rad_en | input | 1 | Capture a read-queue selection from rdadd |
| estr | input | 1 | Capture a flag-bus device selection from rdadd |
| rdadd | input | 6 | [5:3] device identity, [1:0] queue number |
| qout | output | DATA_W | Word on view |
| qout_valid | output | 1 | qout holds an unconsumed word |
| q_empty | output | 4 | Per-queue empty indication |
| q_full | output | 4 | Per-queue full indication |
| flag_sel | output | 1 | This device is selected for the flag bus |

## Verification
The bench aims at the two-edge switch window with ren both high and low. A design that switches one edge early would show the new queue's word in place of the old one. A design that gates the switch on ren would never leave the old queue. Selections with a foreign identity or with rdadd[2] set check that the decode neither swaps queues wrongly nor drops a valid selection. A switch to an empty queue followed by a write checks that qout holds and the word falls through one edge later. Long random runs with unique data expose any pointer that is shared between queues, since that would show up as lost or repeated words, along with writes into full queues.

// File: rtl/mq_pkg.sv
// Shared constants and types of the multi-queue read switcher.
package mq_pkg;
    localparam int ADDR_W = 6;               // read address width
    localparam int DEV_W  = 3;               // device identity field width
    localparam int Q_W    = 2;               // queue number width
    localparam int NQ     = 1 << Q_W;        // number of queues

    // one pending queue selection in the switch pipeline
    typedef struct packed {
        logic           vld;
        logic [Q_W-1:0] q;
    } qsel_t;
endpackage

// File: rtl/mq_store.sv
// Shared storage of all queues with per-queue pointers and occupancy.
// Assumes DEPTH is a power of two. The peek port returns the word that
// will be at the head of peek_q after this edge's pop has been applied.
module mq_store
    import mq_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [Q_W-1:0]    wr_q,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pop_en,
    input  logic [Q_W-1:0]    pop_q,
    input  logic [Q_W-1:0]    peek_q,
    output logic              peek_vld,
    output logic [DATA_W-1:0] peek_data,
    output logic [NQ-1:0]     q_empty,
    output logic [NQ-1:0]     q_full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int MEM_N = NQ * DEPTH;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem    [MEM_N];
    logic [PTR_W-1:0]  rd_ptr [NQ];
    logic [PTR_W-1:0]  wr_ptr [NQ];
    logic [CNT_W-1:0]  cnt    [NQ];

    logic wr_ok;
    logic pop_ok;

    // accept a push only below capacity, a pop only when a word exists
    always_comb begin
        wr_ok  = wr_en && (cnt[wr_q] != FULL_CNT);
        pop_ok = pop_en && (cnt[pop_q] != '0);
    end

    // per-queue pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NQ; i++) begin
                rd_ptr[i] <= '0;
                wr_ptr[i] <= '0;
                cnt[i]    <= '0;
            end
        end else begin
            for (int i = 0; i < NQ; i++) begin
                logic w_i;
                logic r_i;
                w_i = wr_ok && (wr_q == Q_W'(i));
                r_i = pop_ok && (pop_q == Q_W'(i));
                if (w_i) wr_ptr[i] <= wr_ptr[i] + PTR_W'(1);
                if (r_i) rd_ptr[i] <= rd_ptr[i] + PTR_W'(1);
                if (w_i && !r_i)      cnt[i] <= cnt[i] + CNT_W'(1);
                else if (r_i && !w_i) cnt[i] <= cnt[i] - CNT_W'(1);
            end
        end
    end

    // storage array write, not reset
    always_ff @(posedge clk) begin
        if (wr_ok) mem[{wr_q, wr_ptr[wr_q]}] <= wr_data;
    end

    // head of peek_q as it will stand after this edge's pop
    always_comb begin
        logic             same;
        logic [PTR_W-1:0] hp;
        same = pop_ok && (pop_q == peek_q);
        hp   = same ? rd_ptr[peek_q] + PTR_W'(1) : rd_ptr[peek_q];
        peek_vld  = same ? (cnt[peek_q] > CNT_W'(1)) : (cnt[peek_q] != '0);
        peek_data = mem[{peek_q, hp}];
    end

    // status flags, one pair per queue
    for (genvar g = 0; g < NQ; g++) begin : g_flags
        assign q_empty[g] = (cnt[g] == '0);
        assign q_full[g]  = (cnt[g] == FULL_CNT);
    end
endmodule

// File: rtl/mq_sel_pipe.sv
// Read-queue selection pipeline. A selection captured on one edge
// becomes the read queue SW_LAT edges later, independent of any read
// enable. Assumes SW_LAT >= 2.
module mq_sel_pipe
    import mq_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ID = 3'd5,
    parameter int               SW_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rad_en,
    input  logic [DEV_W-1:0] dev_field,
    input  logic [Q_W-1:0]   q_field,
    output logic [Q_W-1:0]   cur_q,
    output logic [Q_W-1:0]   nxt_q
);
    qsel_t stg [SW_LAT];
    logic  hit;

    // selection is taken only when addressed to this device
    assign hit = rad_en && (dev_field == DEV_ID);

    // queue that feeds the output after this edge
    assign nxt_q = stg[SW_LAT-1].vld ? stg[SW_LAT-1].q : cur_q;

    // shift pending selections and retire the oldest into cur_q
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SW_LAT; i++) stg[i] <= '0;
            cur_q <= '0;
        end else begin
            stg[0].vld <= hit;
            stg[0].q   <= q_field;
            for (int i = 1; i < SW_LAT; i++) stg[i] <= stg[i-1];
            cur_q <= nxt_q;
        end
    end
endmodule

// File: rtl/mq_dev_flag.sv
// Flag-bus device select: remembers whether the last strobed identity
// matched this device.
module mq_dev_flag
    import mq_pkg::*;
#(
    parameter logic [DEV_W-1:0] DEV_ID = 3'd5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             estr,
    input  logic [DEV_W-1:0] dev_field,
    output logic             flag_sel
);
    // update only on a strobe, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_sel <= 1'b0;
        else if (estr) flag_sel <= (dev_field == DEV_ID);
    end
endmodule

// File: rtl/mq_out_reg.sv
// Output register: loads the peeked head when one exists, otherwise
// drops valid and keeps the last word.
module mq_out_reg #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              peek_vld,
    input  logic [DATA_W-1:0] peek_data,
    output logic [DATA_W-1:0] qout,
    output logic              qout_valid
);
    // first-word-fall-through view of the read queue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qout       <= '0;
            qout_valid <= 1'b0;
        end else begin
            qout_valid <= peek_vld;
            if (peek_vld) qout <= peek_data;
        end
    end
endmodule

// File: rtl/mq_rd_switch.sv
// Top of the multi-queue read switcher: storage, selection pipeline,
// flag-bus select and output register. Single clock for both ports.
module mq_rd_switch
    import mq_pkg::*;
#(
    parameter int               DATA_W = 18,
    parameter int               DEPTH  = 8,
    parameter logic [DEV_W-1:0] DEV_ID = 3'd5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_queue,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ren,
    input  logic              rad_en,
    input  logic              estr,
    input  logic [5:0]        rdadd,
    output logic [DATA_W-1:0] qout,
    output logic              qout_valid,
    output logic [3:0]        q_empty,
    output logic [3:0]        q_full,
    output logic              flag_sel
);
    logic [DEV_W-1:0]  dev_field;
    logic [Q_W-1:0]    q_field;
    logic              unused_rdadd_bit;
    logic [Q_W-1:0]    cur_q;
    logic [Q_W-1:0]    nxt_q;
    logic              pop_en;
    logic              peek_vld;
    logic [DATA_W-1:0] peek_data;

    // split the read address into identity and queue fields
    assign dev_field        = rdadd[ADDR_W-1 -: DEV_W];
    assign q_field          = rdadd[Q_W-1:0];
    assign unused_rdadd_bit = rdadd[2];

    // a read consumes only a word actually on view
    assign pop_en = ren && qout_valid;

    mq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_q      (wr_queue),
        .wr_data   (wr_data),
        .pop_en    (pop_en),
        .pop_q     (cur_q),
        .peek_q    (nxt_q),
        .peek_vld  (peek_vld),
        .peek_data (peek_data),
        .q_empty   (q_empty),
        .q_full    (q_full)
    );

    mq_sel_pipe #(.DEV_ID(DEV_ID), .SW_LAT(2)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .rad_en    (rad_en),
        .dev_field (dev_field),
        .q_field   (q_field),
        .cur_q     (cur_q),
        .nxt_q     (nxt_q)
    );

    mq_dev_flag #(.DEV_ID(DEV_ID)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .estr      (estr),
        .dev_field (dev_field),
        .flag_sel  (flag_sel)
    );

    mq_out_reg #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .peek_vld   (peek_vld),
        .peek_data  (peek_data),
        .qout       (qout),
        .qout_valid (qout_valid)
    );
endmodule

// File: rtl/mq_rd_switch_chk.sv
// Port-level properties of mq_rd_switch, bound into every instance.
module mq_rd_switch_chk #(
    parameter int         DATA_W = 18,
    parameter logic [2:0] DEV_ID = 3'd5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [1:0]        wr_queue,
    input logic              ren,
    input logic              rad_en,
    input logic              estr,
    input logic [5:0]        rdadd,
    input logic [DATA_W-1:0] qout,
    input logic              qout_valid,
    input logic [3:0]        q_empty,
    input logic [3:0]        q_full,
    input logic              flag_sel
);
    // reset edge leaves everything idle
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!qout_valid && q_empty == 4'hF && q_full == 4'h0 && !flag_sel));

    // no read, no completing switch: the view holds
    p_view_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (qout_valid && !ren && !$past(rad_en && rdadd[5:3] == DEV_ID, 2))
        |=> ($stable(qout) && qout_valid));

    // with nothing valid the word does not move
    p_empty_keeps_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !qout_valid |-> $stable(qout));

    // a matching strobe claims the flag bus
    p_flag_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (estr && rdadd[5:3] == DEV_ID) |=> flag_sel);

    // no strobe, no flag change
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !estr |=> $stable(flag_sel));

    // a write never leaves its queue empty
    p_write_fills_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !q_empty[$past(wr_queue)]);
endmodule

bind mq_rd_switch mq_rd_switch_chk #(.DATA_W(DATA_W), .DEV_ID(DEV_ID)) u_chk (.*);

// File: tb/mq_rd_switch_tb.sv
`timescale 1ns/1ps
module mq_rd_switch_tb;
    localparam int         DW    = 18;
    localparam int         DEPTH = 8;
    localparam logic [2:0] ID    = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_queue = '0;
    logic [DW-1:0] wr_data = '0;
    logic          ren = 1'b0;
    logic          rad_en = 1'b0;
    logic          estr = 1'b0;
    logic [5:0]    rdadd = '0;
    logic [DW-1:0] qout;
    logic          qout_valid;
    logic [3:0]    q_empty;
    logic [3:0]    q_full;
    logic          flag_sel;

    always #2.5 clk = ~clk;

    mq_rd_switch #(.DATA_W(DW), .DEPTH(DEPTH), .DEV_ID(ID)) u_dut (.*);

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;
    int  wcnt  = 0;

    // reference state
    logic [DW-1:0] mq [4][$];
    logic [1:0]    m_cur;
    logic          m_s1v, m_s2v;
    logic [1:0]    m_s1q, m_s2q;
    logic          m_qv, m_flag;
    logic [DW-1:0] m_qout;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] m_empty();
        for (int i = 0; i < 4; i++) m_empty[i] = (mq[i].size() == 0);
    endfunction

    function automatic logic [3:0] m_full();
        for (int i = 0; i < 4; i++) m_full[i] = (mq[i].size() == DEPTH);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) mq[i].delete();
        m_cur = 0; m_s1v = 0; m_s2v = 0; m_s1q = 0; m_s2q = 0;
        m_qv = 0; m_flag = 0; m_qout = '0;
    endtask

    // reference behaviour of one rising edge
    task automatic model_edge();
        logic       pop, wok, pv;
        logic [1:0] nq;
        logic [DW-1:0] pd;
        pop = ren && m_qv;
        nq  = m_s2v ? m_s2q : m_cur;
        pd  = '0;
        if (pop && m_cur == nq) begin
            pv = mq[nq].size() >= 2;
            if (pv) pd = mq[nq][1];
        end else begin
            pv = mq[nq].size() >= 1;
            if (pv) pd = mq[nq][0];
        end
        wok = wr_en && (mq[wr_queue].size() < DEPTH);
        if (pop) void'(mq[m_cur].pop_front());
        if (wok) mq[wr_queue].push_back(wr_data);
        m_qv = pv;
        if (pv) m_qout = pd;
        m_cur = nq;
        m_s2v = m_s1v; m_s2q = m_s1q;
        m_s1v = rad_en && (rdadd[5:3] == ID); m_s1q = rdadd[1:0];
        if (estr) m_flag = (rdadd[5:3] == ID);
    endtask

    // one cycle: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input string tag, input logic iw, input logic [1:0] iq,
                        input logic ir, input logic ia, input logic ie,
                        input logic [5:0] ad);
        wr_en = iw; wr_queue = iq; wr_data = DW'(18'h100 + wcnt);
        if (iw) wcnt++;
        ren = ir; rad_en = ia; estr = ie; rdadd = ad;
        @(posedge clk);
        #1 model_edge();
        @(negedge clk);
        chk(tag, "qout_valid", 32'(qout_valid), 32'(m_qv));
        chk(tag, "qout", 32'(qout), 32'(m_qout));
        chk("R10", "q_empty", 32'(q_empty), 32'(m_empty()));
        chk("R10", "q_full", 32'(q_full), 32'(m_full()));
        chk("R8", "flag_sel", 32'(flag_sel), 32'(m_flag));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "qout_valid", 32'(qout_valid), 0);
        chk("R1", "qout", 32'(qout), 0);
        chk("R1", "q_empty", 32'(q_empty), 32'hF);
        chk("R1", "q_full", 32'(q_full), 0);
        chk("R1", "flag_sel", 32'(flag_sel), 0);

        // fill queue 0 (read queue), queue 1 and overfill queue 2
        for (int i = 0; i < 3; i++) step("R6", 1, 2'd0, 0, 0, 0, 6'd0);
        for (int i = 0; i < 2; i++) step("R5", 1, 2'd1, 0, 0, 0, 6'd0);
        for (int i = 0; i < DEPTH + 2; i++) step("R9", 1, 2'd2, 0, 0, 0, 6'd0);
        chk("R9", "q_full[2]", 32'(q_full[2]), 1);
        chk("R5", "head q0", 32'(qout), 32'h100);
        step("R5", 0, 0, 1, 0, 0, 6'd0);
        chk("R5", "next q0", 32'(qout), 32'h101);
        step("R5", 0, 0, 0, 0, 0, 6'd0);

        // switch to queue 1 with ren low, then with ren high
        step("R3", 0, 0, 0, 1, 0, {ID, 3'b001});
        step("R3", 0, 0, 0, 0, 0, 6'd0);
        chk("R3", "old word", 32'(qout), 32'h101);
        step("R4", 0, 0, 0, 0, 0, 6'd0);
        chk("R4", "new head", 32'(qout), 32'h103);
        step("R3", 0, 0, 1, 1, 0, {ID, 3'b010});
        step("R3", 0, 0, 1, 0, 0, 6'd0);
        step("R4", 0, 0, 1, 0, 0, 6'd0);

        // foreign identity and rad_en low: no switch
        step("R2", 0, 0, 0, 1, 0, {ID ^ 3'b011, 3'b011});
        step("R2", 0, 0, 0, 0, 0, {ID, 3'b011});
        step("R2", 0, 0, 0, 0, 0, 6'd0);

        // rdadd[2] set, empty queue 3
        step("R2", 0, 0, 0, 1, 0, {ID, 3'b111});
        step("R6", 0, 0, 0, 0, 0, 6'd0);
        step("R6", 0, 0, 1, 0, 0, 6'd0);
        chk("R6", "empty view", 32'(qout_valid), 0);
        step("R6", 0, 0, 1, 0, 0, 6'd0);
        step("R6", 1, 2'd3, 0, 0, 0, 6'd0);
        step("R6", 0, 0, 0, 0, 0, 6'd0);
        chk("R6", "fall through", 32'(qout_valid), 1);

        // flag-bus select strobes
        step("R8", 0, 0, 0, 0, 1, {ID, 3'b110});
        chk("R8", "claim", 32'(flag_sel), 1);
        step("R8", 0, 0, 0, 0, 0, {~ID, 3'b000});
        step("R8", 0, 0, 0, 0, 1, {~ID, 3'b101});
        chk("R8", "release", 32'(flag_sel), 0);

        // drain queue 2 in order
        step("R7", 0, 0, 0, 1, 0, {ID, 3'b010});
        for (int i = 0; i < DEPTH + 2; i++) step("R7", 0, 0, 1, 0, 0, 6'd0);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] a;
            a = 6'($urandom);
            if ($urandom_range(0, 9) < 8) a[5:3] = ID;
            step("R7", ($urandom_range(0, 9) < 4), 2'($urandom),
                 ($urandom_range(0, 1) == 1), ($urandom_range(0, 99) < 15),
                 ($urandom_range(0, 99) < 10), a);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule